// File: doc/BRIEF.md
# Clocked Byte Serial Port with Selectable Clock Source

This block moves one byte at a time across a three-wire clocked serial link. Transmit and receive share a single shift register, so every transfer sends the byte that was loaded and captures a byte from the input pin. The host reaches the block through a small register bus with three addresses: data, control and status. To run a transfer, the host writes the byte to send, then writes the control word with the trigger bit set.

A two-bit selector picks the serial clock source. Three codes make the block the master: it divides the system clock by one of three ratios and drives the clock line. The fourth code makes it a slave, clocked by an external line that is passed through a two-flop synchroniser before edge detection. A ready/busy flag is kept in the status register and can also be driven on a pin. A completion flag sets at the end of each byte and clears when status is read. The flag reaches the interrupt output only while its enable bit is set. A polarity bit inverts the logic level on both serial data pins.

Top module: `sxu_top`

## Requirements
- R1: After reset, status bit 0 (ready) reads 1, status bit 1 (completion flag) reads 0, sclk_o is 1, siof_o is 0, irq_o is 0, the data register reads 0x00 and sout_o is 0.
- R2: A write to control (address 1) with bit 4 set starts a transfer. From the next cycle, status bit 0 reads 0 and siof_o is 1. Both hold until the byte completes.
- R3: With control bits [1:0] set to 0, 1 or 2, the block is master: sclk_oe_o is 1 and the clock period is DIV_A, DIV_B or DIV_C system cycles (2, 8 and 32 by default). A transfer gives exactly 8 rising edges and stays busy for exactly 8 clock periods. sclk_o is high whenever no transfer is running.
- R4: Transmit data goes out least significant bit first. Before the k-th rising edge of the serial clock, sout_o holds bit k-1 of the byte written to data (address 0). sout_o changes only after falling edges.
- R5: sin_i is sampled on rising edges of the serial clock. The first sample becomes bit 0. After completion, the data register reads the received byte.
- R6: Control bits [1:0] = 3 selects slave mode. sclk_oe_o is 0, and sclk_i is synchronised through two flops. The transfer completes after 8 external rising edges, using the same bit order as R4 and R5.
- R7: Control bit 2 set inverts the level on both sin_i and sout_o.
- R8: While busy, writes to data and control are ignored, including a trigger. This holds for the transmitted byte, the received byte and the control read-back.
- R9: The completion flag sets when a byte completes and clears on a read of status (address 2). irq_o equals the flag ANDed with control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address: 0 data, 1 control, 2 status |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (clears flag on status) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| sin_i | input | 1 | Serial data in |
| sout_o | output | 1 | Serial data out |
| sclk_i | input | 1 | Serial clock from external master |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_oe_o | output | 1 | Serial clock output enable |
| siof_o | output | 1 | Busy status pin (high while transferring) |
| irq_o | output | 1 | Completion interrupt |

## Verification
The bench uses the default parameters: divide ratios of 2, 8 and 32, a two-stage synchroniser and the status pin enabled. With these ratios every master rate fits in a few hundred cycles, so the exact busy length of 16, 64 and 256 cycles can be counted for each rate. The enabled pin lets the bench follow busy directly at the port. Slave runs use a slow external clock with a half period of six system cycles, which leaves room for the synchroniser delay before the sampling points.

// File: rtl/sxu_pkg.sv
package sxu_pkg;
  typedef enum logic [1:0] {
    SEL_DIV_A = 2'd0,
    SEL_DIV_B = 2'd1,
    SEL_DIV_C = 2'd2,
    SEL_EXT   = 2'd3
  } clk_sel_e;

  localparam logic [1:0] ADDR_DATA   = 2'd0;
  localparam logic [1:0] ADDR_CTRL   = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;

  localparam int CTRL_NEG_BIT  = 2;
  localparam int CTRL_IRQE_BIT = 3;
  localparam int CTRL_TRIG_BIT = 4;

  typedef struct packed {
    logic     irq_en;
    logic     neg_pol;
    clk_sel_e sel;
  } ctrl_t;
endpackage

// File: rtl/sxu_regs.sv
module sxu_regs
  import sxu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] sreg_i,
  output ctrl_t             ctrl_o,
  output logic              start_o,
  output logic              load_o,
  output logic              irq_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t ctrl_q;
  logic  flag_q;
  logic  wr_ctrl, wr_data, rd_stat;

  assign wr_ctrl = we_i && (addr_i == ADDR_CTRL) && !busy_i;
  assign wr_data = we_i && (addr_i == ADDR_DATA) && !busy_i;
  assign rd_stat = re_i && (addr_i == ADDR_STATUS);
  assign start_o = wr_ctrl && wdata_i[CTRL_TRIG_BIT];
  assign load_o  = wr_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.sel     <= clk_sel_e'(wdata_i[1:0]);
      ctrl_q.neg_pol <= wdata_i[CTRL_NEG_BIT];
      ctrl_q.irq_en  <= wdata_i[CTRL_IRQE_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (done_i)  flag_q <= 1'b1;
    else if (rd_stat) flag_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_DATA:   rdata_o = sreg_i;
      ADDR_CTRL:   rdata_o[CTRL_W-1:0] = ctrl_q;
      ADDR_STATUS: rdata_o[1:0] = {flag_q, ~busy_i};
      default:     rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign irq_o  = flag_q & ctrl_q.irq_en;

  p_no_trig_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && we_i) |=> $stable(ctrl_q));
  p_flag_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> flag_q);
endmodule

// File: rtl/sxu_clkgen.sv
module sxu_clkgen
  import sxu_pkg::*;
#(
  parameter int DIV_A       = 2,
  parameter int DIV_B       = 8,
  parameter int DIV_C       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  clk_sel_e sel_i,
  input  logic     busy_i,
  input  logic     sclk_i,
  output logic     sclk_o,
  output logic     sclk_oe_o,
  output logic     rise_o,
  output logic     fall_o
);
  localparam int HALF_A   = DIV_A / 2;
  localparam int HALF_B   = DIV_B / 2;
  localparam int HALF_C   = DIV_C / 2;
  localparam int HALF_MAX = (HALF_A > HALF_B) ? ((HALF_A > HALF_C) ? HALF_A : HALF_C)
                                              : ((HALF_B > HALF_C) ? HALF_B : HALF_C);
  localparam int HW = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;

  logic [HW-1:0] hc_q, half_m1;
  logic          sclk_q, tick, master, run_m, run_s;
  logic [SYNC_STAGES:0] sync_q;
  logic          s_now, s_old;

  assign master = (sel_i != SEL_EXT);
  assign run_m  = busy_i && master;
  assign run_s  = busy_i && !master;

  always_comb begin
    case (sel_i)
      SEL_DIV_A: half_m1 = HW'(HALF_A - 1);
      SEL_DIV_B: half_m1 = HW'(HALF_B - 1);
      default:   half_m1 = HW'(HALF_C - 1);
    endcase
  end

  assign tick = run_m && (hc_q == half_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q   <= '0;
      sclk_q <= 1'b1;
    end else if (!run_m) begin
      hc_q   <= '0;
      sclk_q <= 1'b1;
    end else if (tick) begin
      hc_q   <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      hc_q   <= hc_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], sclk_i};
  end
  assign s_now = sync_q[SYNC_STAGES-1];
  assign s_old = sync_q[SYNC_STAGES];

  assign rise_o    = (tick && !sclk_q) || (run_s && s_now && !s_old);
  assign fall_o    = (tick &&  sclk_q) || (run_s && !s_now && s_old);
  assign sclk_o    = sclk_q;
  assign sclk_oe_o = master;

  p_idle_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> sclk_q);
  p_edges_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o || fall_o) |-> busy_i);
  p_one_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
endmodule

// File: rtl/sxu_shifter.sv
module sxu_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sin_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] sreg_o
);
  localparam int CW = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic [DATA_W-1:0] sreg_q;
  logic [CW-1:0]     cnt_q;
  logic              busy_q, done_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rx_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (load_i) sreg_q <= load_data_i;
        if (start_i) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
        end
      end else if (rise_i) begin
        if (cnt_q == LAST) begin
          // final bit goes straight in; transfer ends with clock high
          sreg_q <= {sin_i, sreg_q[DATA_W-1:1]};
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          rx_q  <= sin_i;
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (fall_i && cnt_q != '0) begin
        sreg_q <= {rx_q, sreg_q[DATA_W-1:1]};
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign sreg_o = sreg_q;

  p_start_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(start_i));
  p_load_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !rise_i && !fall_i) |=> $stable(sreg_q));
  p_done_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!busy_q && $past(busy_q) && $past(rise_i)));
endmodule

// File: rtl/sxu_top.sv
module sxu_top
  import sxu_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int DIV_A         = 2,
  parameter int DIV_B         = 8,
  parameter int DIV_C         = 32,
  parameter int SYNC_STAGES   = 2,
  parameter bit STATUS_PIN_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              sin_i,
  output logic              sout_o,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  output logic              siof_o,
  output logic              irq_o
);
  ctrl_t             ctrl;
  logic              busy, done, start, load, rise, fall;
  logic [DATA_W-1:0] sreg;

  sxu_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .re_i, .wdata_i, .rdata_o,
    .busy_i(busy), .done_i(done), .sreg_i(sreg),
    .ctrl_o(ctrl), .start_o(start), .load_o(load), .irq_o
  );

  sxu_clkgen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C),
               .SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk_i, .rst_ni, .sel_i(ctrl.sel), .busy_i(busy), .sclk_i,
    .sclk_o, .sclk_oe_o, .rise_o(rise), .fall_o(fall)
  );

  sxu_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .start_i(start), .load_i(load), .load_data_i(wdata_i),
    .rise_i(rise), .fall_i(fall), .sin_i(sin_i ^ ctrl.neg_pol),
    .busy_o(busy), .done_o(done), .sreg_o(sreg)
  );

  assign sout_o = sreg[0] ^ ctrl.neg_pol;

  generate
    if (STATUS_PIN_EN) begin : g_pin
      assign siof_o = busy;
    end else begin : g_nopin
      assign siof_o = 1'b0;
    end
  endgenerate

  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(done) || $past(we_i));
endmodule

// File: tb/sxu_top_tb_top.sv
module sxu_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr = '0;
  logic       we = 1'b0, re = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       sin = 1'b0, sout, sclk_in = 1'b1, sclk_out, sclk_oe, siof, irq;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  sxu_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .re_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .sin_i(sin), .sout_o(sout),
    .sclk_i(sclk_in), .sclk_o(sclk_out), .sclk_oe_o(sclk_oe),
    .siof_o(siof), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1; #1 d = rdata;
    @(posedge clk); #1 re = 1'b0;
  endtask

  // master transfer, bench acts as slave device
  task automatic run_master(input logic [1:0] sel, input logic neg, input logic ie,
                            input logic [7:0] tx, input logic [7:0] rx,
                            input int div, input string tag);
    logic [7:0] got = '0, d;
    logic prev = 1'b1, last = 1'b0;
    int busy_n = 0, rises = 0, falls = 0;
    bus_wr(2'd0, tx);
    bus_wr(2'd1, {3'b0, 1'b1, ie, neg, sel});
    check({tag, " R3 oe"}, sclk_oe, 1);
    forever begin
      @(negedge clk);
      if (!sclk_out && prev) begin
        if (falls < 8) sin = rx[falls] ^ neg;
        falls++;
      end
      if (!sclk_out) last = sout;
      if (sclk_out && !prev) begin
        if (rises < 8) got[rises] = last ^ neg;
        rises++;
      end
      prev = sclk_out;
      if (!siof) break;
      busy_n++;
      if (busy_n > 2000) break;
    end
    check({tag, " R3 busy cycles"}, busy_n, 8 * div);
    check({tag, " R3 rises"}, rises, 8);
    check({tag, " R3 idle high"}, sclk_out, 1);
    check({tag, " R4 tx bits"}, got, tx);
    bus_rd(2'd0, d);
    check({tag, " R5 rx byte"}, d, rx);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 sclk", sclk_out, 1);
    check("R1 siof", siof, 0);
    check("R1 irq", irq, 0);
    check("R1 sout", sout, 0);
    bus_rd(2'd2, d); check("R1 status", d, 8'h01);
    bus_rd(2'd0, d); check("R1 data", d, 8'h00);
  endtask

  task automatic t_status;
    logic [7:0] d;
    bus_wr(2'd0, 8'h3C);
    bus_wr(2'd1, 8'h12);
    check("R2 siof busy", siof, 1);
    bus_rd(2'd2, d); check("R2 ready low", d[0], 0);
    while (siof) @(negedge clk);
    bus_rd(2'd2, d); check("R2 ready back", d[0], 1);
  endtask

  task automatic t_busy_ignore;
    logic [7:0] got = '0, d;
    logic prev = 1'b1, last = 1'b0;
    int rises = 0, falls = 0;
    logic [7:0] tx = 8'hA5, rx = 8'h5A;
    bus_wr(2'd0, tx);
    bus_wr(2'd1, 8'h11);          // sel=1, trigger
    @(negedge clk); addr = 2'd0; wdata = 8'hFF; we = 1'b1;
    @(negedge clk); addr = 2'd1; wdata = 8'h1E;
    @(negedge clk); we = 1'b0;
    forever begin
      @(negedge clk);
      if (!sclk_out && prev) begin
        if (falls < 8) sin = rx[falls];
        falls++;
      end
      if (!sclk_out) last = sout;
      if (sclk_out && !prev) begin
        if (rises < 8) got[rises] = last;
        rises++;
      end
      prev = sclk_out;
      if (!siof) break;
    end
    check("R8 tx kept", got, tx);
    bus_rd(2'd0, d); check("R8 rx kept", d, rx);
    bus_rd(2'd1, d); check("R8 ctrl kept", d, 8'h01);
    repeat (4) @(negedge clk);
    check("R8 no retrigger", siof, 0);
  endtask

  task automatic t_slave;
    logic [7:0] got = '0, d;
    logic [7:0] tx = 8'hC3, rx = 8'h96;
    bus_wr(2'd0, tx);
    bus_wr(2'd1, 8'h13);
    check("R6 oe off", sclk_oe, 0);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      sclk_in = 1'b0; sin = rx[i];
      repeat (6) @(negedge clk);
      got[i] = sout;
      sclk_in = 1'b1;
      repeat (6) @(negedge clk);
    end
    check("R6 done", siof, 0);
    check("R6 tx bits", got, tx);
    bus_rd(2'd0, d); check("R6 rx byte", d, rx);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    bus_rd(2'd2, d);              // clear stale flag
    run_master(2'd0, 1'b0, 1'b1, 8'h0F, 8'hF0, 2, "irq");
    repeat (2) @(negedge clk);
    check("R9 irq high", irq, 1);
    bus_rd(2'd2, d); check("R9 flag read", d[1], 1);
    check("R9 irq cleared", irq, 0);
    bus_rd(2'd2, d); check("R9 flag clear", d[1], 0);
    run_master(2'd0, 1'b0, 1'b0, 8'h11, 8'h22, 2, "irqoff");
    repeat (2) @(negedge clk);
    check("R9 gated", irq, 0);
    bus_rd(2'd2, d); check("R9 flag set gated", d[1], 1);
  endtask

  task automatic finish_run;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_status();
    run_master(2'd0, 1'b0, 1'b0, 8'hB4, 8'h6D, 2,  "div_a");
    run_master(2'd1, 1'b0, 1'b0, 8'h81, 8'h7E, 8,  "div_b");
    run_master(2'd2, 1'b0, 1'b0, 8'h5C, 8'hA3, 32, "div_c");
    run_master(2'd1, 1'b1, 1'b0, 8'hE2, 8'h19, 8,  "R7 neg");
    t_busy_ignore();
    t_slave();
    t_irq();
    finish_run();
  end
endmodule